// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by any integer ratio `N*P + A` and marks the end of each division cycle with a one-clock pulse. Inside it, a prescaler stage counts `P` or `P+1` input cycles depending on a modulus-control line. A main counter counts prescaler wraps, and a swallow counter keeps the modulus control at `P+1` for the first `A` prescaler wraps of each output cycle. Because of this, the fast stage stays a fixed two-ratio divider, and the overall ratio still moves in steps of one input period. Everything is modelled as synchronous logic on one clock.

Software or a controller sets the ratio by shifting a word into a serial register and then pulsing a latch strobe. Each latched setting is checked. A good setting goes into shadow registers and takes effect at the next end of cycle. A bad setting raises an error flag and is dropped, and the last good setting stays in use.

Top module: `pulse_swallow_div`

## Requirements
- R1: The interval between consecutive `div_out` pulses is `N*P + A` input clock cycles, where N and A are the setting in force at the start of that interval.
- R2: `div_out` is high for exactly one input clock cycle per division cycle.
- R3: Within each division cycle, `mod_hi` is high for the first `A*(P+1)` input cycles and low for the remaining `(N-A)*P` cycles.
- R4: Each cycle with `ser_en` high shifts `ser_din` into the shift register, MSB first. The word is 19 bits with default parameters: N occupies bits 18..7 and A occupies bits 6..0.
- R5: A pulse on `ser_latch` does not change the division cycle in progress. The new setting applies from the next division cycle.
- R6: A latched word with `N = 0`, `A > N` or `A > P-1` sets `cfg_err` and leaves the setting in force unchanged. A latched word that is valid clears `cfg_err`.
- R7: After reset, `div_out` and `cfg_err` are low, and the setting is N=4, A=2, so `mod_hi` is high. The first division cycle starts at the first clock edge after reset is released.
- R8: The ratio N=2047, A=63 gives 131071 cycles between pulses (with P=64).
- R9: The boundary settings `A = N` (every prescaler wrap at P+1) and `A = 0` (`mod_hi` never high) are accepted and divide correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_en | input | 1 | Shift enable for the serial setting register |
| ser_din | input | 1 | Serial data bit, MSB first |
| ser_latch | input | 1 | Strobe that checks the shifted word and transfers it to the shadow setting |
| div_out | output | 1 | One-cycle pulse at the end of each division cycle |
| mod_hi | output | 1 | Modulus control: high selects P+1 in the prescaler |
| cfg_err | output | 1 | High after a rejected setting, until the next valid latch |

## Verification
The bench goes after the edges of the swallow window. If the `mod_hi` drop is off by one prescaler wrap, every period is wrong by one cycle. With `A = N`, a design that lets the swallow count reach zero one wrap late would run past the main terminal count. A latch placed in the middle of a cycle shows up a design that reloads at once, because that design emits a short period. The three kinds of rejected setting check that a design does not store bad values and does not hold the error flag after a good latch. One period longer than 131000 cycles shows whether the main counter is wide enough.

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int P_MOD  = 64,
  parameter int N_W    = 12,
  parameter int N_INIT = 4,
  parameter int A_INIT = 2,
  localparam int A_W = $clog2(P_MOD + 1),
  localparam int W_W = N_W + A_W,
  localparam int C_W = $clog2(P_MOD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_en,
  input  logic ser_din,
  input  logic ser_latch,
  output logic div_out,
  output logic mod_hi,
  output logic cfg_err
);

  logic [W_W-1:0] shreg;
  logic [N_W-1:0] n_sh, n_cnt;
  logic [A_W-1:0] a_sh, a_cnt;
  logic [C_W-1:0] pc;

  wire [N_W-1:0] new_n = shreg[W_W-1:A_W];
  wire [A_W-1:0] new_a = shreg[A_W-1:0];
  wire new_ok = (new_n != '0) && (N_W'(new_a) <= new_n) && (new_a <= A_W'(P_MOD - 1));

  assign mod_hi = (a_cnt != '0);
  wire [C_W-1:0] pc_last = mod_hi ? C_W'(P_MOD) : C_W'(P_MOD - 1);
  wire pre_tick = (pc == pc_last);
  wire wrap = pre_tick && (n_cnt == N_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      n_sh    <= N_W'(N_INIT);
      a_sh    <= A_W'(A_INIT);
      n_cnt   <= N_W'(N_INIT);
      a_cnt   <= A_W'(A_INIT);
      pc      <= '0;
      div_out <= 1'b0;
      cfg_err <= 1'b0;
    end else begin
      if (ser_en) shreg <= {shreg[W_W-2:0], ser_din};
      if (ser_latch) begin
        cfg_err <= !new_ok;
        if (new_ok) begin
          n_sh <= new_n;
          a_sh <= new_a;
        end
      end
      pc      <= pre_tick ? '0 : pc + 1'b1;
      div_out <= wrap;
      if (wrap) begin
        n_cnt <= n_sh;
        a_cnt <= a_sh;
      end else if (pre_tick) begin
        n_cnt <= n_cnt - 1'b1;
        if (mod_hi) a_cnt <= a_cnt - 1'b1;
      end
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out);

  a_r1_pulse_on_restart: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |-> pc == '0);

  a_r3_mod_moves_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (pc != '0) |-> $stable(mod_hi));

  a_r3_low_modulus_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_hi |-> pc < C_W'(P_MOD));

  a_r3_swallow_within_main: assert property (@(posedge clk) disable iff (!rst_n)
    N_W'(a_cnt) <= n_cnt);

  a_r6_setting_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (n_sh != '0) && (N_W'(a_sh) <= n_sh) && (a_sh <= A_W'(P_MOD - 1)));

endmodule

// File: tb/test_pulse_swallow_div.sv
module test_pulse_swallow_div;
  localparam int P  = 64;
  localparam int NW = 12;
  localparam int AW = $clog2(P + 1);
  localparam int WW = NW + AW;
  localparam int LIMIT = 195000;

  logic clk = 0, rst_n = 0, ser_en = 0, ser_din = 0, ser_latch = 0;
  logic div_out, mod_hi, cfg_err;

  pulse_swallow_div i_pulse_swallow_div (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_din(ser_din),
    .ser_latch(ser_latch), .div_out(div_out), .mod_hi(mod_hi), .cfg_err(cfg_err)
  );

  always #10 clk = ~clk;

  int n_total = 0, n_bad = 0, cyc = 0;
  string phase = "R7";

  int pos = 0, cur_n = 4, cur_a = 2, sh_n = 4, sh_a = 2;
  logic exp_div = 0, exp_err = 0;
  logic [WW-1:0] msh = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst_n) begin
      int nn, aa;
      pos++;
      exp_div = 0;
      if (pos == cur_n * P + cur_a) begin
        pos = 0;
        exp_div = 1;
        cur_n = sh_n;
        cur_a = sh_a;
      end
      if (ser_latch) begin
        nn = int'(msh >> AW);
        aa = int'(msh) % (1 << AW);
        if (nn >= 1 && aa <= nn && aa <= P - 1) begin
          sh_n = nn; sh_a = aa; exp_err = 0;
        end else exp_err = 1;
      end
      if (ser_en) msh = {msh[WW-2:0], ser_din};
    end
    if (cyc > LIMIT) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_total, n_bad);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(div_out == exp_div, {"R1/R2 div_out ", phase}, div_out, exp_div);
      chk(mod_hi == (pos < cur_a * (P + 1)), {"R3 mod_hi ", phase}, mod_hi,
          int'(pos < cur_a * (P + 1)));
      chk(cfg_err == exp_err, {"R6 cfg_err ", phase}, cfg_err, exp_err);
    end
  end

  task automatic load(input int n, input int a);
    logic [WW-1:0] w;
    w = {n[NW-1:0], a[AW-1:0]};
    for (int i = WW - 1; i >= 0; i--) begin
      @(negedge clk);
      ser_en = 1; ser_din = w[i];
    end
    @(negedge clk);
    ser_en = 0; ser_din = 0; ser_latch = 1;
    @(negedge clk);
    ser_latch = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    run(3);
    chk(div_out == 0, "R7 reset div_out", div_out, 0);
    chk(cfg_err == 0, "R7 reset cfg_err", cfg_err, 0);
    chk(mod_hi == 1, "R7 reset mod_hi", mod_hi, 1);
    rst_n = 1;
    phase = "R7 R1 default";
    run(600);
    phase = "R4 R1 load 7/3";
    load(7, 3);
    run(1000);
    phase = "R5 R9 mid-cycle load 5/0";
    run(100);
    load(5, 0);
    run(800);
    phase = "R9 A equals N 6/6";
    load(6, 6);
    run(900);
    phase = "R6 A above N";
    load(3, 5);
    run(200);
    phase = "R6 A above P-1";
    load(100, 64);
    run(200);
    phase = "R6 N zero";
    load(0, 0);
    run(500);
    phase = "R6 valid clears 2/1";
    load(2, 1);
    run(400);
    phase = "R8 long ratio 2047/63";
    load(2047, 63);
    run(131500);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_total, n_bad);
    $finish;
  end
endmodule